// File: doc/BRIEF.md
# Transmitter Delay Compensation Bit Checker

This block checks that a CAN FD node reads back the bits it drives during the fast data phase. At that bit rate the round trip through the transceiver and the bus can last longer than one bit time, so the comparison cannot happen at the ordinary sample point. At the start of each data phase the block times the loop: it counts system clocks from the first dominant (falling) edge the node drives on its transmit line to the matching falling edge on its receive line. A glitch filter can reject receive edges that arrive too early.

Every later bit start pushes the transmitted level into a small queue, together with the clock count at which that bit should be compared. That point is the measured delay plus a programmed offset, and is called the secondary sample point. Several bits can be queued at once. When a queue entry comes due, the received level is compared with the stored bit. Any mismatch is held until the next regular sample point strobe. At that strobe the block gives the protocol state machine a one-cycle error pulse. The offset is used exactly as programmed. A usual starting value is the effective data-phase segment-1 length in time quanta, for example 7.

Top module: `tdc_checker`

## Requirements
- R1: While `data_phase_i` is low, `bit_err_o` is 0 in the following cycle. No measurement is made and no bit is checked.
- R2: The loop delay equals the number of clock edges from the edge at which the first falling transition of `tx_i` in the data phase is seen to the edge at which an accepted falling transition of `rx_i` is seen. Both lines are recessive at 1 and dominant at 0. The delay is 0 if both transitions are seen at the same edge.
- R3: A falling `rx_i` transition is accepted only when the running delay count is at least `filter_i`. Earlier transitions are ignored. A `filter_i` of 0 accepts the first transition.
- R4: The secondary sample point position is the delay plus `offset_i`, with no +1 added, and an offset of 0 is legal. The received level is compared at the clock edge that comes position+1 edges after the bit-start edge.
- R5: A bit start (`bit_start_i` high at an edge) stores the value of `tx_i` at that edge. A check reports an error when `rx_i` at the compare edge differs from the stored value.
- R6: Up to DEPTH bits can wait for their compare edge at the same time, so the delay may exceed one bit time. Bits that start at or before the edge where the measurement completes are not checked.
- R7: Check results are ORed together and held. At an edge with `sample_pt_i` high, the held value appears on `bit_err_o` for exactly one cycle. A result produced at that same edge is counted toward the following sample point. `bit_err_o` is 0 in every other cycle.
- R8: The position saturates at SSP_MAX (default 63). `ssp_sat_o` is 1 while a measured delay plus `offset_i` is at least SSP_MAX.
- R9: When `data_phase_i` goes low, the queued bits, the held result and the measured delay are discarded, and `ssp_sat_o` returns to 0. The next data phase measures afresh.
- R10: During reset `bit_err_o` and `ssp_sat_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_phase_i | input | 1 | High for the whole fast data phase |
| tx_i | input | 1 | Transmit line level driven by the node |
| rx_i | input | 1 | Receive line level returned by the transceiver |
| bit_start_i | input | 1 | One-clock strobe at the first clock of each transmitted bit |
| sample_pt_i | input | 1 | One-clock strobe at the regular sample point |
| offset_i | input | OFF_W | Secondary sample point offset in clocks |
| filter_i | input | FLT_W | Minimum delay count before a receive edge is accepted |
| bit_err_o | output | 1 | Bit-error pulse to the protocol state machine |
| ssp_sat_o | output | 1 | Secondary sample point clamped at its maximum |

## Verification
The bench targets several corner cases. It runs a loop delay longer than a bit, which needs several queued bits. A design holding only one bit would drop or mismatch checks. It runs a zero offset with a short two-clock corruption window. Adding a hidden +1 would move the compare edge off the corrupted clocks. An early receive glitch is run both with the filter on and with the filter off, so a design that ignores `filter_i` latches the glitch as the delay. A large offset forces saturation, and an unclamped position would compare a later bit. The bench also corrupts the last bits before a data phase ends and then runs a clean frame. A design that fails to flush would release a stale error or a stale queue entry.

// File: rtl/tdc_pkg.sv
// Shared types for the transmitter delay compensation checker.
package tdc_pkg;

    // Loop delay measurement progress within one data phase.
    typedef enum logic [1:0] {
        MS_WAIT  = 2'd0,   // waiting for the first dominant edge on TX
        MS_COUNT = 2'd1,   // counting clocks until RX follows
        MS_DONE  = 2'd2    // delay captured, held until phase end
    } meas_state_e;

endpackage

// File: rtl/tdc_delay_meas.sv
// Loop delay timer.
// Counts clocks from the first falling TX edge of a data phase to the first
// falling RX edge that arrives no earlier than the filter window.
// Assumes edge strobes come from registered line levels; the count
// saturates at MAX_CNT; everything clears while the data phase is low.
module tdc_delay_meas
    import tdc_pkg::*;
#(
    parameter int DLY_W   = 6,
    parameter int FLT_W   = 4,
    parameter int MAX_CNT = 63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             tx_fall_i,
    input  logic             rx_fall_i,
    input  logic [FLT_W-1:0] filter_i,
    output logic             done_o,
    output logic [DLY_W-1:0] delay_o
);

    localparam int CW = ((DLY_W > FLT_W) ? DLY_W : FLT_W) + 1;

    meas_state_e      state_q;
    logic [DLY_W-1:0] cnt_q;
    logic             accept_now;

    // Receive edge is accepted once the running count reaches the window.
    assign accept_now = rx_fall_i && (CW'(cnt_q) >= CW'(filter_i));

    // Measurement sequence: wait for TX edge, count, capture once.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            state_q <= MS_WAIT;
            cnt_q   <= '0;
            delay_o <= '0;
        end else begin
            case (state_q)
                MS_WAIT: begin
                    if (tx_fall_i) begin
                        if (rx_fall_i && (filter_i == '0)) begin
                            state_q <= MS_DONE;
                            delay_o <= '0;
                        end else begin
                            state_q <= MS_COUNT;
                            cnt_q   <= DLY_W'(1);
                        end
                    end
                end
                MS_COUNT: begin
                    if (accept_now) begin
                        state_q <= MS_DONE;
                        delay_o <= cnt_q;
                    end else if (cnt_q != DLY_W'(MAX_CNT)) begin
                        cnt_q <= cnt_q + DLY_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign done_o = (state_q == MS_DONE);

endmodule

// File: rtl/tdc_ssp_fifo.sv
// In-flight bit queue.
// Holds transmitted bits with their compare times in arrival order.
// Assumes the caller never pushes when full; a flush empties it at once.
module tdc_ssp_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_i,
    input  logic                         push_i,
    input  logic [W-1:0]                 push_data_i,
    input  logic                         pop_i,
    output logic [W-1:0]                 head_o,
    output logic                         head_valid_o,
    output logic                         full_o,
    output logic [$clog2(DEPTH+1)-1:0]   level_o
);

    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH+1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] wr_q;
    logic [PW-1:0] rd_q;
    logic          do_push;
    logic          do_pop;

    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && head_valid_o;

    // Entry storage write.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[wr_q] <= push_data_i;
        end
    end

    // Pointer and occupancy bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_q    <= '0;
            rd_q    <= '0;
            level_o <= '0;
        end else begin
            if (do_push) begin
                wr_q <= (wr_q == PW'(DEPTH-1)) ? '0 : wr_q + PW'(1);
            end
            if (do_pop) begin
                rd_q <= (rd_q == PW'(DEPTH-1)) ? '0 : rd_q + PW'(1);
            end
            if (do_push && !do_pop) begin
                level_o <= level_o + LVL_W'(1);
            end else if (do_pop && !do_push) begin
                level_o <= level_o - LVL_W'(1);
            end
        end
    end

    assign head_o       = mem_q[rd_q];
    assign head_valid_o = (level_o != '0);
    assign full_o       = (level_o == LVL_W'(DEPTH));

endmodule

// File: rtl/tdc_err_hold.sv
// Result holder.
// ORs check results and releases them as a one-cycle pulse at the regular
// sample point; a result arriving at that same edge waits for the next one.
// Assumes the data phase input clears everything when low.
module tdc_err_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic res_valid_i,
    input  logic res_err_i,
    input  logic sample_pt_i,
    output logic bit_err_o
);

    logic pend_q;
    logic new_err;

    assign new_err = res_valid_i && res_err_i;

    // Accumulate mismatches and report them at each sample point.
    always_ff @(posedge clk) begin
        if (!rst_n || !active_i) begin
            pend_q    <= 1'b0;
            bit_err_o <= 1'b0;
        end else if (sample_pt_i) begin
            bit_err_o <= pend_q;
            pend_q    <= new_err;
        end else begin
            bit_err_o <= 1'b0;
            pend_q    <= pend_q | new_err;
        end
    end

endmodule

// File: rtl/tdc_checker.sv
// Transmitter delay compensation bit checker, top level.
// Measures the loop delay once per data phase, queues each transmitted bit
// with its secondary sample point time, compares it with RX when due and
// passes the result on at the regular sample point.
// Assumes bit_start_i coincides with the new TX level, DEPTH is a power of
// two and the time stamp counter outruns SSP_MAX+1.
module tdc_checker #(
    parameter int OFF_W   = 6,
    parameter int FLT_W   = 4,
    parameter int SSP_MAX = 63,
    parameter int DEPTH   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_phase_i,
    input  logic             tx_i,
    input  logic             rx_i,
    input  logic             bit_start_i,
    input  logic             sample_pt_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic [FLT_W-1:0] filter_i,
    output logic             bit_err_o,
    output logic             ssp_sat_o
);

    localparam int DLY_W = $clog2(SSP_MAX+1);
    localparam int SUM_W = ((DLY_W > OFF_W) ? DLY_W : OFF_W) + 1;
    localparam int TW    = $clog2(SSP_MAX+2) + 1;
    localparam int ENT_W = TW + 1;
    localparam int LVL_W = $clog2(DEPTH+1);

    logic             tx_q;
    logic             rx_q;
    logic             tx_fall;
    logic             rx_fall;
    logic [TW-1:0]    now_q;
    logic             meas_done;
    logic [DLY_W-1:0] meas_delay;
    logic [SUM_W-1:0] ssp_sum;
    logic [DLY_W-1:0] ssp_pos;
    logic             ssp_clamped;
    logic [ENT_W-1:0] push_ent;
    logic [ENT_W-1:0] head_ent;
    logic             head_valid;
    logic             fifo_full;
    logic [LVL_W-1:0] fifo_level;
    logic             push;
    logic             pop;
    logic             head_bit;
    logic [TW-1:0]    head_due;

    // Previous line levels for falling edge detection; idle is recessive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= 1'b1;
            rx_q <= 1'b1;
        end else begin
            tx_q <= tx_i;
            rx_q <= rx_i;
        end
    end

    assign tx_fall = tx_q && !tx_i;
    assign rx_fall = rx_q && !rx_i;

    // Free-running time stamp used for compare deadlines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q <= '0;
        end else begin
            now_q <= now_q + TW'(1);
        end
    end

    tdc_delay_meas #(
        .DLY_W   (DLY_W),
        .FLT_W   (FLT_W),
        .MAX_CNT (SSP_MAX)
    ) u_meas (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (data_phase_i),
        .tx_fall_i (tx_fall),
        .rx_fall_i (rx_fall),
        .filter_i  (filter_i),
        .done_o    (meas_done),
        .delay_o   (meas_delay)
    );

    // Secondary sample point position with saturation.
    always_comb begin
        ssp_sum     = SUM_W'(meas_delay) + SUM_W'(offset_i);
        ssp_clamped = (ssp_sum >= SUM_W'(SSP_MAX));
        ssp_pos     = ssp_clamped ? DLY_W'(SSP_MAX) : ssp_sum[DLY_W-1:0];
    end

    assign ssp_sat_o = meas_done && ssp_clamped;

    // Queue entry: transmitted bit and the stamp at which it is compared.
    assign push     = data_phase_i && meas_done && bit_start_i;
    assign push_ent = {tx_i, now_q + TW'(ssp_pos) + TW'(1)};
    assign head_bit = head_ent[ENT_W-1];
    assign head_due = head_ent[TW-1:0];
    assign pop      = data_phase_i && head_valid && (head_due == now_q);

    tdc_ssp_fifo #(
        .DEPTH (DEPTH),
        .W     (ENT_W)
    ) u_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (!data_phase_i),
        .push_i       (push),
        .push_data_i  (push_ent),
        .pop_i        (pop),
        .head_o       (head_ent),
        .head_valid_o (head_valid),
        .full_o       (fifo_full),
        .level_o      (fifo_level)
    );

    tdc_err_hold u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .active_i    (data_phase_i),
        .res_valid_i (pop),
        .res_err_i   (head_bit != rx_i),
        .sample_pt_i (sample_pt_i),
        .bit_err_o   (bit_err_o)
    );

    logic unused_full;
    assign unused_full = fifo_full;

endmodule

// File: rtl/tdc_checker_sva.sv
// Property checker for tdc_checker, attached by bind below.
module tdc_checker_sva #(
    parameter int DLY_W = 6,
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             data_phase_i,
    input logic             sample_pt_i,
    input logic             bit_err_o,
    input logic             ssp_sat_o,
    input logic             meas_done,
    input logic [DLY_W-1:0] meas_delay,
    input logic [LVL_W-1:0] fifo_level
);

    // R1: no error report follows a cycle outside the data phase.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !data_phase_i |=> !bit_err_o);

    // R7: an error pulse always follows a regular sample point strobe.
    a_r7_pulse_after_sp: assert property (@(posedge clk) disable iff (!rst_n)
        bit_err_o |-> $past(sample_pt_i));

    // R9: queue emptied after the data phase ends.
    a_r9_flush_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        !data_phase_i |=> (fifo_level == '0));

    // R9: saturation status clears with the measured delay.
    a_r9_sat_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !data_phase_i |=> !ssp_sat_o);

    // R2: a captured delay does not move while it stays valid.
    a_r2_delay_held: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_done && $past(meas_done)) |-> $stable(meas_delay));

endmodule

bind tdc_checker tdc_checker_sva #(
    .DLY_W (DLY_W),
    .LVL_W (LVL_W)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .data_phase_i (data_phase_i),
    .sample_pt_i  (sample_pt_i),
    .bit_err_o    (bit_err_o),
    .ssp_sat_o    (ssp_sat_o),
    .meas_done    (meas_done),
    .meas_delay   (meas_delay),
    .fifo_level   (fifo_level)
);

// File: tb/sim_tdc_checker.sv
// Scoreboard bench: a frame driver models the bus loop, predicts every
// regular sample point report and queues it; a monitor compares each cycle.
module sim_tdc_checker;

    localparam int CLK_PERIOD = 10;
    localparam int OFF_W      = 6;
    localparam int FLT_W      = 4;
    localparam int SSP_MAX    = 63;
    localparam int DEPTH      = 8;
    localparam int BIT_LEN    = 10;
    localparam int SP_POS     = 8;
    localparam int TAIL       = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             data_phase_i = 1'b0;
    logic             tx_i = 1'b1;
    logic             rx_i = 1'b1;
    logic             bit_start_i = 1'b0;
    logic             sample_pt_i = 1'b0;
    logic [OFF_W-1:0] offset_i = '0;
    logic [FLT_W-1:0] filter_i = '0;
    logic             bit_err_o;
    logic             ssp_sat_o;

    tdc_checker #(
        .OFF_W   (OFF_W),
        .FLT_W   (FLT_W),
        .SSP_MAX (SSP_MAX),
        .DEPTH   (DEPTH)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_phase_i (data_phase_i),
        .tx_i         (tx_i),
        .rx_i         (rx_i),
        .bit_start_i  (bit_start_i),
        .sample_pt_i  (sample_pt_i),
        .offset_i     (offset_i),
        .filter_i     (filter_i),
        .bit_err_o    (bit_err_o),
        .ssp_sat_o    (ssp_sat_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int gcnt = 0;
    always @(posedge clk) gcnt <= gcnt + 1;

    typedef struct {
        int    t;
        bit    e;
        string tag;
    } exp_t;

    exp_t  exp_q[$];
    int    n_chk = 0;
    int    n_err = 0;
    bit    mon_en = 1'b0;
    bit    txa [1024];
    bit    rxa [1024];
    bit    cor [1024];
    int    chk_at [64];
    bit    chk_err [64];
    bit    chk_ok [64];

    task automatic check(input bit act, input bit exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0b expected=%0b at edge %0d", tag, act, exp, gcnt);
        end
    endtask

    function automatic bit bval(input int k);
        if (k == 0) return 1'b0;
        return ((k * 7 + 3) % 5) < 2;
    endfunction

    // Monitor: pulse expected only at predicted sample point edges (R7).
    always @(negedge clk) begin
        if (mon_en) begin
            bit    ex;
            string tg;
            ex = 1'b0;
            tg = "R7 quiet";
            if (exp_q.size() > 0 && exp_q[0].t == gcnt) begin
                ex = exp_q[0].e;
                tg = exp_q[0].tag;
                void'(exp_q.pop_front());
            end
            check(bit_err_o, ex, tg);
        end
    end

    // Driver: build the bus model, push predictions, then play the frame.
    task automatic run_frame(input int dly, input int off, input int filt,
                             input int nb, input int glitch, input int corr_len,
                             input logic [31:0] cmask, input string tag,
                             input bit exp_sat);
        int ph, tot, dm, ssp, base, prev;
        ph  = 2 + BIT_LEN * nb;
        tot = ph + TAIL;
        for (int e = 0; e < 1024; e++) begin
            txa[e] = 1'b1;
            cor[e] = 1'b0;
        end
        for (int k = 0; k < nb; k++) begin
            for (int j = 0; j < BIT_LEN; j++) begin
                txa[2 + BIT_LEN*k + j] = bval(k);
                cor[2 + BIT_LEN*k + j] = cmask[k] && (j < corr_len);
            end
        end
        for (int e = 0; e < 1024; e++) begin
            rxa[e] = (e >= dly) ? (txa[e-dly] ^ cor[e-dly]) : 1'b1;
        end
        if (glitch > 0) rxa[glitch] = 1'b0;
        // Expected delay: first accepted falling RX edge (R2, R3).
        dm = -1;
        for (int e = 2; e <= ph; e++) begin
            if (dm < 0 && rxa[e] == 1'b0 && rxa[e-1] == 1'b1 && (e - 2) >= filt) dm = e - 2;
        end
        ssp = (dm + off > SSP_MAX) ? SSP_MAX : dm + off;
        // Compare edges per bit (R4, R5, R6).
        for (int k = 0; k < nb; k++) begin
            int b, c;
            b = 2 + BIT_LEN*k;
            c = b + ssp + 1;
            chk_ok[k]  = (b > 2 + dm) && (c <= ph);
            chk_at[k]  = c;
            chk_err[k] = (rxa[c] != txa[b]);
        end
        base = gcnt;
        prev = 0;
        for (int j = 0; j < nb; j++) begin
            int t;
            bit ex;
            t  = 2 + BIT_LEN*j + SP_POS;
            ex = 1'b0;
            if (t <= ph) begin
                for (int k = 0; k < nb; k++) begin
                    if (chk_ok[k] && chk_at[k] >= prev && chk_at[k] < t && chk_err[k]) ex = 1'b1;
                end
                exp_q.push_back('{base + t, ex, tag});
                prev = t;
            end
        end
        offset_i = OFF_W'(off);
        filter_i = FLT_W'(filt);
        for (int e = 1; e <= tot; e++) begin
            tx_i         = txa[e];
            rx_i         = rxa[e];
            data_phase_i = (e <= ph);
            bit_start_i  = (e <= ph) && (e >= 2) && ((e - 2) % BIT_LEN == 0);
            sample_pt_i  = (e <= ph) && (e >= 2 + SP_POS) && ((e - 2 - SP_POS) % BIT_LEN == 0);
            @(negedge clk);
            if (e == 40) check(ssp_sat_o, exp_sat, "R8 saturation flag");
        end
        check(ssp_sat_o, 1'b0, "R9 flag cleared after phase");
        check(bit_err_o, 1'b0, "R1 idle after phase");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(bit_err_o, 1'b0, "R10 reset error output");
        check(ssp_sat_o, 1'b0, "R10 reset saturation output");
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;
        repeat (3) @(negedge clk);
        // R2: clean loop, nominal offset
        run_frame(6, 7, 0, 12, 0, BIT_LEN, 32'h0, "R2 clean loop", 1'b0);
        // R5: corrupted bits, last one falls past phase end
        run_frame(6, 7, 0, 12, 0, BIT_LEN, 32'h0000_0888, "R5 mismatch", 1'b0);
        // R9: clean frame right after; stale results must be gone
        run_frame(6, 7, 0, 12, 0, BIT_LEN, 32'h0, "R9 after flush", 1'b0);
        // R6: delay longer than a bit, several bits queued
        run_frame(15, 7, 0, 12, 0, BIT_LEN, 32'h0000_0030, "R6 long delay", 1'b0);
        // R4: zero offset, two-clock corruption window
        run_frame(6, 0, 0, 12, 0, 2, 32'h0000_0120, "R4 zero offset", 1'b0);
        // R3: early glitch rejected by filter
        run_frame(6, 0, 4, 12, 4, 2, 32'h0000_0020, "R3 filter on", 1'b0);
        // R3: filter off, glitch taken as the delay
        run_frame(6, 0, 0, 12, 4, 2, 32'h0000_0020, "R3 filter off", 1'b0);
        // R8: offset large enough to clamp
        run_frame(6, 60, 0, 12, 0, BIT_LEN, 32'h0000_0040, "R8 clamp", 1'b1);
        // R1: bit starts and sample points outside the phase do nothing
        repeat (4) begin
            bit_start_i = 1'b1;
            sample_pt_i = 1'b1;
            tx_i        = 1'b0;
            rx_i        = 1'b1;
            @(negedge clk);
            check(bit_err_o, 1'b0, "R1 strobes outside phase");
        end
        bit_start_i = 1'b0;
        sample_pt_i = 1'b0;
        tx_i        = 1'b1;
        repeat (4) @(negedge clk);
        mon_en = 1'b0;
        if (exp_q.size() != 0) begin
            n_chk++;
            n_err++;
            $display("FAIL R7: actual=%0d expected=0 unconsumed predictions", exp_q.size());
        end
        finish_run();
    end

endmodule